// File: doc/BRIEF.md
# Activity-Weighted Round-Robin Slot Arbiter

This arbiter hands out the access slots of a shared wide memory to a set of ports. Time is cut into loops of `NPORT` consecutive cycles, the first loop beginning on the first clock edge after reset. Each cycle it issues at most one registered grant, one bit per port.

It has two modes. In skip mode it rotates among the ports that are requesting in that cycle and passes over idle ones. In weighted mode it fixes a slot budget for every port at the start of each loop. The budget follows the data each port moved over the last `HIST_LOOPS` loop windows. Every requesting port gets at least one slot. The remaining slots go to the ports with the most recent traffic. Within a loop, the budgeted slots are handed out in rotating order so that no port's accesses are bunched together.

The transfer counts are supplied per port and per cycle by the port logic. The data path and the memory sit outside this block.

Top module: `slot_arbiter`

## Requirements
- R1: While `rst` is high, and in the cycle it is released, `grant` is all zero. The first loop starts at the first rising edge after reset is released, and reset may be reapplied at any time.
- R2: `grant` is registered and has at most one bit set in every cycle. Bit i grants port i.
- R3: With `mode` = 0 (skip), each edge grants the first port in `req` (bit i = port i) at or after the last granted port plus one, wrapping around. A grant is issued exactly when some request is present, so with all ports requesting the grant rotates 0,1,2,3.
- R4: With `mode` = 1 (weighted), the slot budget of a loop is computed at its first edge from `req` at that edge. The budget then holds for the whole loop, and requests dropped mid-loop do not remove slots already budgeted.
- R5: A port's busy measure at a loop start is the sum of its `xfer_cnt` values over the last `HIST_LOOPS` windows of `NPORT` edges. Each window ends at a loop start, and older traffic has no effect.
- R6: In weighted mode, every requesting port gets at least one slot. If any port requests, all `NPORT` slots of the loop are granted, and ports not requesting get none.
- R7: Slots beyond one per requesting port go one at a time to the requesting port with the largest residual busy measure, with ties going to the lowest index. That port's residual then drops by the step (saturating at zero). The step is the total busy measure of the requesting ports divided by `NPORT`.
- R8: In weighted mode, a loop that starts with no request grants nothing, whatever the transfer counts are.
- R9: In weighted mode, slots are picked in rotating order after the last granted port among ports with budget left. For example, two ports with two slots each alternate in every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 1 | 0 = skip round-robin, 1 = weighted |
| req | input | NPORT | Per-port pending-request flags |
| xfer_cnt | input | NPORT*CNT_W | Per-port data count moved this cycle, port i at bits [i*CNT_W +: CNT_W] |
| grant | output | NPORT | Registered one-hot-or-zero grant |

## Verification
The properties assume that `mode` and `req` are synchronous to `clk`. They also assume that the skip-mode checks see the same `req` that the arbiter sampled one edge earlier, so inputs must not change between that edge and the sample. The stimulus drives every input on the falling edge and changes it only at loop boundaries, apart from one deliberate mid-loop request drop. It holds each setting for three loops before counting slots, so that both history windows contain only the new traffic. The transfer counts stay small enough that no accumulator can wrap.

// File: rtl/slot_arb_pkg.sv
`timescale 1ns/1ps
package slot_arb_pkg;
  typedef enum logic {
    ARB_SKIP     = 1'b0,
    ARB_WEIGHTED = 1'b1
  } arb_mode_e;
endpackage

// File: rtl/slot_hist.sv
`timescale 1ns/1ps
// Per-port traffic history: running sum of the current window plus
// HIST_LOOPS-1 completed windows.
module slot_hist #(
  parameter int NPORT      = 4,
  parameter int CNT_W      = 8,
  parameter int HIST_LOOPS = 2,
  parameter int LOOP_W     = 11,
  parameter int BUSY_W     = 13
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              loop_start,
  input  logic [NPORT*CNT_W-1:0]            xfer_cnt,
  output logic [NPORT-1:0][BUSY_W-1:0]      busy
);
  localparam int DEPTH = HIST_LOOPS - 1;

  logic [NPORT-1:0][LOOP_W-1:0]             acc_q;
  logic [NPORT-1:0][LOOP_W-1:0]             cur_win;
  logic [DEPTH-1:0][NPORT-1:0][LOOP_W-1:0]  win_q;

  always_comb begin
    for (int p = 0; p < NPORT; p++) begin
      cur_win[p] = acc_q[p] + LOOP_W'(xfer_cnt[p*CNT_W +: CNT_W]);
      busy[p]    = BUSY_W'(cur_win[p]);
      for (int d = 0; d < DEPTH; d++)
        busy[p] = busy[p] + BUSY_W'(win_q[d][p]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
      win_q <= '0;
    end else if (loop_start) begin
      acc_q    <= '0;
      win_q[0] <= cur_win;
      for (int d = 1; d < DEPTH; d++)
        win_q[d] <= win_q[d-1];
    end else begin
      acc_q <= cur_win;
    end
  end
endmodule

// File: rtl/slot_alloc.sv
`timescale 1ns/1ps
// Combinational slot budget: one slot per active port, then the extra
// slots by largest residual busy measure.
module slot_alloc #(
  parameter int NPORT  = 4,
  parameter int BUSY_W = 13,
  parameter int CRED_W = 3
) (
  input  logic [NPORT-1:0]              active,
  input  logic [NPORT-1:0][BUSY_W-1:0]  busy,
  output logic [NPORT-1:0][CRED_W-1:0]  credit
);
  localparam int  IDX_W = $clog2(NPORT);
  localparam int  TOT_W = BUSY_W + $clog2(NPORT);
  localparam int  NUM_W = $clog2(NPORT + 1);
  localparam bit  POW2  = (NPORT & (NPORT - 1)) == 0;

  logic [TOT_W-1:0]             total;
  logic [TOT_W-1:0]             step;
  logic [NUM_W-1:0]             n_active;
  logic [NPORT-1:0][BUSY_W-1:0] resid;
  logic [IDX_W-1:0]             best;
  logic [BUSY_W-1:0]            best_v;
  logic                         found;

  always_comb begin
    total    = '0;
    n_active = '0;
    for (int p = 0; p < NPORT; p++) begin
      if (active[p]) begin
        total    = total + TOT_W'(busy[p]);
        n_active = n_active + 1'b1;
      end
    end
  end

  generate
    if (POW2) begin : gen_step_shift
      assign step = total >> IDX_W;
    end else begin : gen_step_div
      assign step = total / TOT_W'(NPORT);
    end
  endgenerate

  always_comb begin
    credit = '0;
    resid  = '0;
    best   = '0;
    best_v = '0;
    found  = 1'b0;
    for (int p = 0; p < NPORT; p++) begin
      if (active[p]) begin
        resid[p]  = busy[p];
        credit[p] = CRED_W'(1);
      end
    end
    for (int it = 0; it < NPORT; it++) begin
      if (n_active != '0 && it < NPORT - int'(n_active)) begin
        found  = 1'b0;
        best   = '0;
        best_v = '0;
        for (int p = 0; p < NPORT; p++) begin
          if (active[p] && (!found || resid[p] > best_v)) begin
            found  = 1'b1;
            best   = IDX_W'(p);
            best_v = resid[p];
          end
        end
        credit[best] = credit[best] + 1'b1;
        if (TOT_W'(resid[best]) > step)
          resid[best] = resid[best] - BUSY_W'(step);
        else
          resid[best] = '0;
      end
    end
  end
endmodule

// File: rtl/slot_seq.sv
`timescale 1ns/1ps
// Slot counter, per-loop budget register and rotating grant picker.
module slot_seq
  import slot_arb_pkg::*;
#(
  parameter int NPORT  = 4,
  parameter int CRED_W = 3
) (
  input  logic                             clk,
  input  logic                             rst,
  input  arb_mode_e                        mode,
  input  logic [NPORT-1:0]                 req,
  input  logic [NPORT-1:0][CRED_W-1:0]     credit_new,
  output logic                             loop_start,
  output logic [NPORT-1:0]                 grant
);
  localparam int IDX_W = $clog2(NPORT);

  logic [IDX_W-1:0]             slot_q;
  logic [IDX_W-1:0]             last_q;
  logic [IDX_W-1:0]             pick_idx;
  logic                         pick_any;
  logic [NPORT-1:0]             elig;
  logic [NPORT-1:0]             pick_oh;
  logic [NPORT-1:0][CRED_W-1:0] cred_q;
  logic [NPORT-1:0][CRED_W-1:0] cred_eff;
  int                           cand;

  assign loop_start = (slot_q == '0);

  always_comb begin
    for (int p = 0; p < NPORT; p++) begin
      cred_eff[p] = loop_start ? credit_new[p] : cred_q[p];
      elig[p]     = (mode == ARB_WEIGHTED) ? (cred_eff[p] != '0) : req[p];
    end
    pick_any = 1'b0;
    pick_idx = '0;
    cand     = 0;
    for (int off = 1; off <= NPORT; off++) begin
      cand = (int'(last_q) + off) % NPORT;
      if (!pick_any && elig[cand]) begin
        pick_any = 1'b1;
        pick_idx = IDX_W'(cand);
      end
    end
    pick_oh = '0;
    if (pick_any) pick_oh[pick_idx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_q <= '0;
      last_q <= IDX_W'(NPORT - 1);
      cred_q <= '0;
      grant  <= '0;
    end else begin
      grant  <= pick_oh;
      slot_q <= (slot_q == IDX_W'(NPORT - 1)) ? '0 : slot_q + 1'b1;
      if (pick_any) last_q <= pick_idx;
      for (int p = 0; p < NPORT; p++)
        cred_q[p] <= (pick_oh[p] && cred_eff[p] != '0) ? cred_eff[p] - 1'b1
                                                       : cred_eff[p];
    end
  end
endmodule

// File: rtl/slot_arbiter.sv
`timescale 1ns/1ps
module slot_arbiter
  import slot_arb_pkg::*;
#(
  parameter int NPORT      = 4,
  parameter int CNT_W      = 8,
  parameter int HIST_LOOPS = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   mode,
  input  logic [NPORT-1:0]       req,
  input  logic [NPORT*CNT_W-1:0] xfer_cnt,
  output logic [NPORT-1:0]       grant
);
  localparam int LOOP_W = CNT_W + $clog2(NPORT) + 1;
  localparam int BUSY_W = LOOP_W + $clog2(HIST_LOOPS) + 1;
  localparam int CRED_W = $clog2(NPORT + 1);

  logic                         loop_start;
  logic [NPORT-1:0][BUSY_W-1:0] busy;
  logic [NPORT-1:0][CRED_W-1:0] credit_new;

  slot_hist #(
    .NPORT(NPORT), .CNT_W(CNT_W), .HIST_LOOPS(HIST_LOOPS),
    .LOOP_W(LOOP_W), .BUSY_W(BUSY_W)
  ) u_hist (
    .clk(clk), .rst(rst), .loop_start(loop_start),
    .xfer_cnt(xfer_cnt), .busy(busy)
  );

  slot_alloc #(
    .NPORT(NPORT), .BUSY_W(BUSY_W), .CRED_W(CRED_W)
  ) u_alloc (
    .active(req), .busy(busy), .credit(credit_new)
  );

  slot_seq #(
    .NPORT(NPORT), .CRED_W(CRED_W)
  ) u_seq (
    .clk(clk), .rst(rst), .mode(arb_mode_e'(mode)), .req(req),
    .credit_new(credit_new), .loop_start(loop_start), .grant(grant)
  );
endmodule

// File: rtl/slot_arbiter_chk.sv
`timescale 1ns/1ps
module slot_arbiter_chk #(
  parameter int NPORT = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             mode,
  input logic [NPORT-1:0] req,
  input logic [NPORT-1:0] grant
);
  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant)); // R2

  AST_RESET_IDLE: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> grant == '0); // R1

  AST_SKIP_ONLY_REQ: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(mode) && grant != '0) |-> (grant & $past(req)) != '0); // R3

  AST_SKIP_NO_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(mode) && $past(req) != '0) |-> grant != '0); // R3
endmodule

bind slot_arbiter slot_arbiter_chk #(.NPORT(NPORT)) u_chk (
  .clk(clk), .rst(rst), .mode(mode), .req(req), .grant(grant)
);

// File: tb/slot_arbiter_bench.sv
`timescale 1ns/1ps
module slot_arbiter_bench;
  localparam int N  = 4;
  localparam int CW = 8;
  localparam int NV = 10;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            mode = 1'b0;
  logic [N-1:0]    req = '0;
  logic [N*CW-1:0] xfer = '0;
  logic [N-1:0]    grant;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  int cnt [N];

  always #4 clk = ~clk;

  slot_arbiter #(.NPORT(N), .CNT_W(CW), .HIST_LOOPS(2)) u_slot_arbiter (
    .clk(clk), .rst(rst), .mode(mode), .req(req), .xfer_cnt(xfer), .grant(grant)
  );

  // [48] mode, [47:44] req, [43:12] xfer port3..0, [11:0] expected slots port3..0
  localparam logic [48:0] VEC [NV] = '{
    {1'b0, 4'b1111, 32'h0,                       {3'd1, 3'd1, 3'd1, 3'd1}},
    {1'b0, 4'b0101, 32'h0,                       {3'd0, 3'd2, 3'd0, 3'd2}},
    {1'b1, 4'b1111, {8'd0, 8'd0, 8'd0, 8'd4},    {3'd1, 3'd1, 3'd1, 3'd1}},
    {1'b1, 4'b0011, {8'd0, 8'd0, 8'd2, 8'd10},   {3'd0, 3'd0, 3'd1, 3'd3}},
    {1'b1, 4'b0011, {8'd0, 8'd0, 8'd2, 8'd0},    {3'd0, 3'd0, 3'd3, 3'd1}},
    {1'b1, 4'b0111, {8'd0, 8'd6, 8'd1, 8'd1},    {3'd0, 3'd2, 3'd1, 3'd1}},
    {1'b1, 4'b1001, {8'd3, 8'd0, 8'd0, 8'd3},    {3'd2, 3'd0, 3'd0, 3'd2}},
    {1'b1, 4'b0000, {8'd5, 8'd5, 8'd5, 8'd5},    {3'd0, 3'd0, 3'd0, 3'd0}},
    {1'b1, 4'b0001, 32'h0,                       {3'd0, 3'd0, 3'd0, 3'd4}},
    {1'b1, 4'b1110, {8'd8, 8'd2, 8'd2, 8'd0},    {3'd2, 3'd1, 3'd1, 3'd0}}
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step_cycle();
    @(posedge clk);
    @(negedge clk);
    check($countones(grant) <= 1, "R2 onehot", int'(grant), 0);
    for (int p = 0; p < N; p++) if (grant[p]) cnt[p]++;
  endtask

  task automatic run_loop();
    for (int p = 0; p < N; p++) cnt[p] = 0;
    repeat (N) step_cycle();
  endtask

  initial begin
    logic [N-1:0] prev;
    repeat (3) @(negedge clk);
    req  = 4'b1111;
    @(negedge clk);
    check(grant == '0, "R1 grant in reset", int'(grant), 0);
    rst = 1'b0;

    for (int v = 0; v < NV; v++) begin
      mode = VEC[v][48];
      req  = VEC[v][47:44];
      xfer = VEC[v][43:12];
      repeat (3) run_loop();
      run_loop();
      for (int p = 0; p < N; p++)
        check(cnt[p] == int'(VEC[v][p*3 +: 3]),
              mode ? (req == '0 ? "R8 idle loop" : "R5 R6 R7 slot budget")
                   : "R3 skip share",
              cnt[p], int'(VEC[v][p*3 +: 3]));
    end

    // R9: two ports with two slots each alternate every cycle
    mode = 1'b1; req = 4'b1001; xfer = {8'd3, 8'd0, 8'd0, 8'd3};
    repeat (3) run_loop();
    prev = grant;
    for (int c = 0; c < 2 * N; c++) begin
      step_cycle();
      check(grant != '0 && grant != prev, "R9 spread", int'(grant), -1);
      prev = grant;
    end

    // R4: requests dropped after the first slot keep the loop's budget
    req = 4'b0011; xfer = {8'd0, 8'd0, 8'd2, 8'd10};
    repeat (3) run_loop();
    for (int p = 0; p < N; p++) cnt[p] = 0;
    step_cycle();
    req = 4'b0000;
    repeat (N - 1) step_cycle();
    check(cnt[0] == 3, "R4 held budget port0", cnt[0], 3);
    check(cnt[1] == 1, "R4 held budget port1", cnt[1], 1);
    run_loop();
    check(cnt[0] + cnt[1] + cnt[2] + cnt[3] == 0, "R8 next loop idle",
          cnt[0] + cnt[1] + cnt[2] + cnt[3], 0);

    // R3: skip mode rotates in index order
    mode = 1'b0; req = 4'b1111; xfer = '0;
    step_cycle();
    prev = grant;
    for (int c = 0; c < N; c++) begin
      step_cycle();
      check(grant == {prev[N-2:0], prev[N-1]}, "R3 rotation", int'(grant),
            int'({prev[N-2:0], prev[N-1]}));
      prev = grant;
    end

    // R1: reset mid-run clears the grant and restarts the loop
    mode = 1'b1;
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check(grant == '0, "R1 mid-run reset", int'(grant), 0);
    rst = 1'b0;
    run_loop();
    for (int p = 0; p < N; p++)
      check(cnt[p] == 1, "R1 R6 first loop after reset", cnt[p], 1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog R1 actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule